// File: doc/BRIEF.md
# Temperature Limit Interrupt Logic

This block watches a stream of signed 8-bit temperature samples in whole degrees Celsius. It keeps one status bit that records an over-temperature condition. Each time a sample-valid strobe arrives, the sample is compared with a programmable high limit and a lower hysteresis limit. How the status bit is set, held and re-armed depends on a 2-bit mode input, which picks one of three policies:

- **repeating:** the bit sets again after every conversion until the temperature falls below hysteresis.
- **one-shot:** the bit sets once and is not re-armed until the temperature drops below hysteresis.
- **level comparator:** the bit follows the over-limit condition.

Software clears the bit with a read strobe. An interrupt-clear level freezes the block: while it is high, samples are ignored, the status bit is held, and the interrupt request is forced inactive. The status bit passes through a per-source mask, giving a request that feeds the system interrupt line. A global enable then produces an active-low interrupt pin.

Top module: `temp_alarm_unit`

## Requirements
- R1: Temperature, high limit and hysteresis limit are 8-bit two's complement (for example 8'h7D is +125 and 8'hD8 is -40). A sample counts as over the limit only when it is strictly greater than the high limit, and as below hysteresis only when it is strictly less than the hysteresis limit, both compared as signed values.
- R2: In repeating mode (mode 2'b00), an accepted sample above the high limit sets the status bit in the cycle after the strobe.
- R3: In repeating mode, after a clear, every later accepted sample sets the status bit again while the temperature has not yet dropped below hysteresis since the last over-limit sample. Once a sample below hysteresis is seen, no further set happens until a new over-limit sample.
- R4: In one-shot mode (mode 2'b01), an over-limit sample sets the status bit only when the block is armed; setting disarms it. A sample below hysteresis re-arms it. Reset leaves the block armed.
- R5: In level comparator mode (mode 2'b10), an accepted sample sets the status bit when it is over the limit and clears it when it is not.
- R6: A read strobe clears the status bit in the next cycle. If a set event falls in the same cycle as the read strobe, the bit stays set.
- R7: While the interrupt-clear input is high, sample strobes are ignored, the status bit keeps its value, and both the request and the interrupt pin are inactive.
- R8: The request is high when the status bit is 1, the mask input is 0 and interrupt-clear is low. The active-low interrupt pin is 0 exactly when the request is high and the enable input is 1.
- R9: After reset the status bit is 0, the request is 0 and the interrupt pin is 1.
- R10: Mode 2'b11 behaves exactly as repeating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One-cycle strobe: new temperature sample |
| sample_temp | input | 8 | Signed temperature sample, degrees Celsius |
| lim_high | input | 8 | Signed high limit |
| lim_hyst | input | 8 | Signed hysteresis (low) limit |
| mode_sel | input | 2 | 00 repeating, 01 one-shot, 10 level, 11 repeating |
| stat_rd | input | 1 | One-cycle strobe: status read, clears the bit |
| irq_clr | input | 1 | Level: freeze sampling and silence the interrupt |
| src_mask | input | 1 | 1 masks this source from the request |
| irq_en | input | 1 | 1 enables the interrupt pin |
| status_bit | output | 1 | Temperature status bit |
| irq_req | output | 1 | Masked request toward the interrupt line |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The status bit is a register. It changes on the first rising edge that sees a sample or read strobe, so it is due one cycle after the stimulus. The request and the pin are combinational from the status bit and the mask, clear and enable inputs, so they change in the same cycle as those inputs. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass, and compares all three outputs on the following falling edge. At that point the inputs still hold the values that produced the register update, so the gating terms are checked against the same inputs. A reference model in the bench advances in step, one update per driven cycle.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
  typedef enum logic [1:0] {
    TM_REPEAT = 2'b00,
    TM_ONCE   = 2'b01,
    TM_LEVEL  = 2'b10,
    TM_ALT    = 2'b11
  } tmode_e;
endpackage

// File: rtl/temp_cmp.sv
module temp_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] temp,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] hyst,
  output logic         over,
  output logic         under
);
  // strictly greater, signed
  function automatic logic is_above(input logic [W-1:0] a, input logic [W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  // strictly less, signed
  function automatic logic is_below(input logic [W-1:0] a, input logic [W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  assign over  = is_above(temp, hi);
  assign under = is_below(temp, hyst);
endmodule

// File: rtl/temp_alarm_fsm.sv
module temp_alarm_fsm
  import temp_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       over,
  input  logic       under,
  input  logic [1:0] mode_sel,
  input  logic       rd_clr,
  output logic       status_q
);
  tmode_e md;
  logic   armed_q, hot_q;
  logic   set_evt, drop_evt;
  logic   status_d, armed_d, hot_d;

  assign md = tmode_e'(mode_sel);

  always_comb begin
    set_evt  = 1'b0;
    drop_evt = 1'b0;
    case (md)
      TM_ONCE:  set_evt = take & over & armed_q;
      TM_LEVEL: begin
        set_evt  = take & over;
        drop_evt = take & ~over;
      end
      default:  set_evt = take & (over | (hot_q & ~under));
    endcase
  end

  always_comb begin
    if (set_evt)                status_d = 1'b1;
    else if (rd_clr | drop_evt) status_d = 1'b0;
    else                        status_d = status_q;

    if (set_evt && md == TM_ONCE) armed_d = 1'b0;
    else if (take && under)       armed_d = 1'b1;
    else                          armed_d = armed_q;

    if (take && over)       hot_d = 1'b1;
    else if (take && under) hot_d = 1'b0;
    else                    hot_d = hot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      armed_q  <= 1'b1;
      hot_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      armed_q  <= armed_d;
      hot_q    <= hot_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> status_q); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_evt) |=> !status_q); // R6
  AST_ONCE_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (md == TM_ONCE && !armed_q && !(take && under)) |=> !$rose(status_q)); // R4
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (md == TM_LEVEL && take && !over) |=> !status_q); // R5
  AST_REPEAT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((md == TM_REPEAT || md == TM_ALT) && take && over) |=> status_q); // R2
endmodule

// File: rtl/temp_irq_gate.sv
module temp_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic status,
  input  logic mask,
  input  logic freeze,
  input  logic en,
  output logic req,
  output logic pin_n
);
  assign req   = status & ~mask & ~freeze;
  assign pin_n = ~(req & en);

  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (pin_n && !req)); // R7
  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask || !en) |-> pin_n); // R8
endmodule

// File: rtl/temp_alarm_unit.sv
module temp_alarm_unit #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic [TW-1:0] sample_temp,
  input  logic [TW-1:0] lim_high,
  input  logic [TW-1:0] lim_hyst,
  input  logic [1:0]    mode_sel,
  input  logic          stat_rd,
  input  logic          irq_clr,
  input  logic          src_mask,
  input  logic          irq_en,
  output logic          status_bit,
  output logic          irq_req,
  output logic          irq_n
);
  logic take, over, under;

  assign take = sample_vld & ~irq_clr;

  temp_cmp #(.W(TW)) u_cmp (
    .temp (sample_temp),
    .hi   (lim_high),
    .hyst (lim_hyst),
    .over (over),
    .under(under)
  );

  temp_alarm_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .over    (over),
    .under   (under),
    .mode_sel(mode_sel),
    .rd_clr  (stat_rd),
    .status_q(status_bit)
  );

  temp_irq_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .status(status_bit),
    .mask  (src_mask),
    .freeze(irq_clr),
    .en    (irq_en),
    .req   (irq_req),
    .pin_n (irq_n)
  );

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !stat_rd) |=> $stable(status_bit)); // R7
endmodule

// File: tb/temp_alarm_unit_test.sv
module temp_alarm_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_vld = 1'b0;
  logic [7:0] sample_temp = '0;
  logic [7:0] lim_high = 8'd25;
  logic [7:0] lim_hyst = 8'd20;
  logic [1:0] mode_sel = 2'b00;
  logic       stat_rd = 1'b0;
  logic       irq_clr = 1'b0;
  logic       src_mask = 1'b0;
  logic       irq_en = 1'b1;
  logic       status_bit, irq_req, irq_n;

  int n_chk = 0, n_fail = 0;
  bit m_st = 0, m_arm = 1, m_hot = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  temp_alarm_unit uut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_temp(sample_temp),
    .lim_high(lim_high), .lim_hyst(lim_hyst), .mode_sel(mode_sel), .stat_rd(stat_rd),
    .irq_clr(irq_clr), .src_mask(src_mask), .irq_en(irq_en),
    .status_bit(status_bit), .irq_req(irq_req), .irq_n(irq_n)
  );

  function automatic int to_int(input logic [7:0] v);
    return (v >= 8'd128) ? int'(v) - 256 : int'(v);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, check at the next falling edge
  task automatic cyc(input string tag, input bit vld, input logic [7:0] t,
                     input bit rd, input bit clr);
    bit acc, hot_over, cold, fire, drop, once, lvl, req_e;
    sample_vld = vld; sample_temp = t; stat_rd = rd; irq_clr = clr;
    acc      = vld && !clr;
    hot_over = to_int(t) > to_int(lim_high);
    cold     = to_int(t) < to_int(lim_hyst);
    once     = (mode_sel == 2'b01);
    lvl      = (mode_sel == 2'b10);
    if (once)     fire = acc && hot_over && m_arm;
    else if (lvl) fire = acc && hot_over;
    else          fire = acc && (hot_over || (m_hot && !cold));
    drop = rd || (lvl && acc && !hot_over);
    if (fire) m_st = 1; else if (drop) m_st = 0;
    if (once && fire) m_arm = 0; else if (acc && cold) m_arm = 1;
    if (acc && hot_over) m_hot = 1; else if (acc && cold) m_hot = 0;
    @(posedge clk);
    @(negedge clk);
    req_e = m_st && !src_mask && !clr;
    chk(tag, "status_bit", status_bit, m_st);
    chk(tag, "irq_req", irq_req, req_e);
    chk(tag, "irq_n", irq_n, !(req_e && irq_en));
    sample_vld = 0; stat_rd = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "status_bit", status_bit, 1'b0);
    chk("R9", "irq_req", irq_req, 1'b0);
    chk("R9", "irq_n", irq_n, 1'b1);
    rst_n = 1;
    @(negedge clk);

    // R1 boundary: equal to limit does not count, one above does
    cyc("R1", 1, 8'd25, 0, 0);
    cyc("R1", 1, 8'd26, 0, 0);
    // R6 read clears; read with set event keeps the bit
    cyc("R6", 0, 8'd0, 1, 0);
    cyc("R6", 1, 8'd30, 1, 0);
    // R3 repeat while not below hysteresis
    cyc("R3", 0, 8'd0, 1, 0);
    cyc("R3", 1, 8'd22, 0, 0);
    cyc("R3", 1, 8'd20, 1, 0);
    cyc("R3", 1, 8'd19, 1, 0);
    cyc("R3", 1, 8'd22, 0, 0);
    // R2 set on over
    cyc("R2", 1, 8'd40, 0, 0);
    // R4 one-shot
    mode_sel = 2'b01;
    cyc("R4", 0, 8'd0, 1, 0);
    cyc("R4", 1, 8'd30, 0, 0);
    cyc("R4", 0, 8'd0, 1, 0);
    cyc("R4", 1, 8'd30, 0, 0);
    cyc("R4", 1, 8'd10, 0, 0);
    cyc("R4", 1, 8'd30, 0, 0);
    // R5 level
    mode_sel = 2'b10;
    cyc("R5", 1, 8'd24, 0, 0);
    cyc("R5", 1, 8'd30, 0, 0);
    cyc("R5", 1, 8'd25, 0, 0);
    cyc("R5", 1, 8'd26, 0, 0);
    // R7 freeze: sample ignored, status held, interrupt silent
    cyc("R7", 1, 8'd10, 0, 1);
    cyc("R7", 0, 8'd0, 0, 1);
    cyc("R7", 0, 8'd0, 0, 0);
    // R8 mask and enable
    src_mask = 1;
    cyc("R8", 0, 8'd0, 0, 0);
    src_mask = 0; irq_en = 0;
    cyc("R8", 0, 8'd0, 0, 0);
    irq_en = 1;
    // R10 mode 11 as repeating, negative limits for R1
    mode_sel = 2'b11; lim_high = 8'hE7; lim_hyst = 8'hD8;
    cyc("R10", 0, 8'd0, 1, 0);
    cyc("R10", 1, 8'hE7, 0, 0);
    cyc("R10", 1, 8'hE8, 0, 0);
    cyc("R10", 0, 8'd0, 1, 0);
    cyc("R10", 1, 8'hD8, 0, 0);
    cyc("R1", 1, 8'hD7, 0, 0);
    cyc("R1", 0, 8'd0, 1, 0);
    cyc("R1", 1, 8'hD8, 0, 0);

    // constrained random across all modes (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] base, t;
      if (i % 100 == 0) begin
        base = 8'($urandom_range(0, 255));
        lim_high = base;
        lim_hyst = base - 8'($urandom_range(0, 12));
        mode_sel = 2'($urandom_range(0, 3));
        src_mask = ($urandom_range(0, 7) == 0);
        irq_en   = ($urandom_range(0, 7) != 0);
      end
      t = lim_high + 8'($urandom_range(0, 30)) - 8'd18;
      cyc("R2", ($urandom_range(0, 2) != 0), t,
          ($urandom_range(0, 4) == 0), ($urandom_range(0, 9) == 0));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule